// File: doc/BRIEF.md
# SECDED Hamming Codec

This block protects small data words stored in memory with a Hamming code that corrects one flipped bit and detects two. The encode path takes a data word and returns a codeword made of the data bits, a set of Hamming check bits placed at the power-of-two positions, and one overall parity bit at the top. The decode path takes a codeword read back from storage. It recomputes the check bits, forms the syndrome, repairs a single flipped bit and returns the data together with the syndrome and two status flags.

Both paths have the same timing. A valid strobe comes in with the operands, and exactly one clock later a valid strobe comes out with registered results. New operands may be presented on every cycle. The default width is 4 data bits, which gives an 8-bit codeword. The data width is a parameter, and the number of check bits follows from it.

Top module: `secded_codec`

## Requirements
- R1: Codeword bit k (0-based) holds code position k+1. Positions 3, 5, 6 and 7 carry data bits 0, 1, 2 and 3 in that order (bits 2, 4, 5 and 6 of the word).
- R2: The check bit at position 2^c (word bit 2^c-1) is the XOR of every data position whose index has bit c set. Word bit 0 covers positions 3, 5 and 7. Word bit 1 covers positions 3, 6 and 7. Word bit 3 covers positions 5, 6 and 7.
- R3: Word bit 7 (the overall parity bit) makes the number of ones across all 8 codeword bits even.
- R4: Each output valid goes high in exactly the cycle after its input valid was sampled, and it is low in every other cycle. Back-to-back inputs give back-to-back outputs.
- R5: A codeword with no flipped bit decodes to its data with syndrome 0 and both flags low.
- R6: A single flip at a data position gives the original data. The syndrome equals that position, the corrected flag is 1 and the uncorrectable flag is 0.
- R7: A single flip at a check position (1, 2 or 4) leaves the data unchanged. The syndrome equals that position and the corrected flag is 1.
- R8: A flip of the overall parity bit alone gives syndrome 0 with the corrected flag set and the data unchanged.
- R9: Any two flipped bits raise the uncorrectable flag and clear the corrected flag. The syndrome is the XOR of the two positions, and the parity bit counts as 0 there.
- R10: While reset is held, and until the first input after reset, both output valids and all result outputs are 0.
- R11: The corrected flag and the uncorrectable flag are never set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_vld_i | input | 1 | Encode request valid |
| enc_data_i | input | DATA_W (4) | Data word to encode |
| enc_vld_o | output | 1 | Encode result valid |
| enc_word_o | output | CW_W (8) | Encoded codeword |
| dec_vld_i | input | 1 | Decode request valid |
| dec_word_i | input | CW_W (8) | Codeword read back from storage |
| dec_vld_o | output | 1 | Decode result valid |
| dec_data_o | output | DATA_W (4) | Corrected data |
| dec_syn_o | output | CHK_W (3) | Syndrome |
| dec_fix_o | output | 1 | A single-bit error was corrected |
| dec_bad_o | output | 1 | Uncorrectable double-bit error |

## Verification
The encoder is driven with all sixteen data values. The data positions, each check bit and the overall parity are compared separately, so a swapped field or a wrong coverage set shows up as a distinct failure. The decoder gets clean codewords, every single-bit flip across all eight positions, and every pair of flips for several data values. These three groups tell apart correction at a data position, syndromes that point at check bits only, a lone flip of the parity bit, and double-error detection. The stimulus mixes back-to-back requests with idle gaps, which separates a correct one-cycle valid from a stuck or delayed one.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // number of Hamming check bits needed for a data width
    function automatic int chk_count(int dw);
        int k;
        k = 1;
        while ((1 << k) < dw + k + 1) k++;
        return k;
    endfunction

    // code position (1-based) of the idx-th data bit: the idx-th non power of two
    function automatic int data_pos(int idx);
        int cnt;
        cnt = 0;
        for (int p = 3; p < 4096; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

    typedef enum logic [1:0] {
        CLS_CLEAN = 2'd0,
        CLS_FIXED = 2'd1,
        CLS_BAD   = 2'd2
    } cls_e;

endpackage

// File: rtl/secded_enc_core.sv
module secded_enc_core #(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0]                                  data_i,
    output logic [DATA_W+secded_pkg::chk_count(DATA_W):0]      word_o
);
    localparam int CHK_W = secded_pkg::chk_count(DATA_W);
    localparam int POS_N = DATA_W + CHK_W;

    logic [POS_N:0] cw;
    logic           acc;

    always_comb begin
        cw  = '0;
        acc = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            cw[secded_pkg::data_pos(i) - 1] = data_i[i];
        end
        for (int c = 0; c < CHK_W; c++) begin
            acc = 1'b0;
            for (int p = 1; p <= POS_N; p++) begin
                if (((p >> c) & 1) == 1 && p != (1 << c)) acc = acc ^ cw[p-1];
            end
            cw[(1 << c) - 1] = acc;
        end
        cw[POS_N] = ^cw[POS_N-1:0];
    end

    assign word_o = cw;

endmodule

// File: rtl/secded_dec_core.sv
module secded_dec_core #(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W+secded_pkg::chk_count(DATA_W):0]  word_i,
    output logic [DATA_W-1:0]                              data_o,
    output logic [secded_pkg::chk_count(DATA_W)-1:0]       syn_o,
    output secded_pkg::cls_e                               cls_o
);
    localparam int CHK_W = secded_pkg::chk_count(DATA_W);
    localparam int POS_N = DATA_W + CHK_W;

    logic [CHK_W-1:0] syn;
    logic [POS_N-1:0] fixed;
    logic             perr;
    logic             acc;

    always_comb begin
        syn = '0;
        acc = 1'b0;
        // stored check XOR recomputed check, folded into one sum per check bit
        for (int c = 0; c < CHK_W; c++) begin
            acc = 1'b0;
            for (int p = 1; p <= POS_N; p++) begin
                if (((p >> c) & 1) == 1) acc = acc ^ word_i[p-1];
            end
            syn[c] = acc;
        end
        perr  = ^word_i;
        fixed = word_i[POS_N-1:0];
        cls_o = secded_pkg::CLS_CLEAN;
        if (perr) begin
            if (syn == '0) begin
                cls_o = secded_pkg::CLS_FIXED;
            end else if (int'(syn) <= POS_N) begin
                cls_o = secded_pkg::CLS_FIXED;
                fixed[int'(syn) - 1] = ~fixed[int'(syn) - 1];
            end else begin
                cls_o = secded_pkg::CLS_BAD;
            end
        end else if (syn != '0) begin
            cls_o = secded_pkg::CLS_BAD;
        end
        for (int i = 0; i < DATA_W; i++) begin
            data_o[i] = fixed[secded_pkg::data_pos(i) - 1];
        end
    end

    assign syn_o = syn;

endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
    parameter int DATA_W = 4,
    localparam int CHK_W = secded_pkg::chk_count(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_vld_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_vld_o,
    output logic [CW_W-1:0]   enc_word_o,
    input  logic              dec_vld_i,
    input  logic [CW_W-1:0]   dec_word_i,
    output logic              dec_vld_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [CHK_W-1:0]  dec_syn_o,
    output logic              dec_fix_o,
    output logic              dec_bad_o
);
    typedef struct packed {
        logic              ev;
        logic [CW_W-1:0]   ew;
        logic              dv;
        logic [DATA_W-1:0] dd;
        logic [CHK_W-1:0]  ds;
        logic              df;
        logic              db;
    } st_t;

    st_t st_d, st_q;

    logic [CW_W-1:0]   enc_word;
    logic [DATA_W-1:0] dec_data;
    logic [CHK_W-1:0]  dec_syn;
    secded_pkg::cls_e  dec_cls;

    secded_enc_core #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_data_i),
        .word_o (enc_word)
    );

    secded_dec_core #(.DATA_W(DATA_W)) u_dec (
        .word_i (dec_word_i),
        .data_o (dec_data),
        .syn_o  (dec_syn),
        .cls_o  (dec_cls)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ev = enc_vld_i;
        st_d.dv = dec_vld_i;
        if (enc_vld_i) st_d.ew = enc_word;
        if (dec_vld_i) begin
            st_d.dd = dec_data;
            st_d.ds = dec_syn;
            st_d.df = (dec_cls == secded_pkg::CLS_FIXED);
            st_d.db = (dec_cls == secded_pkg::CLS_BAD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enc_vld_o  = st_q.ev;
    assign enc_word_o = st_q.ew;
    assign dec_vld_o  = st_q.dv;
    assign dec_data_o = st_q.dd;
    assign dec_syn_o  = st_q.ds;
    assign dec_fix_o  = st_q.df;
    assign dec_bad_o  = st_q.db;

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
    parameter int DATA_W = 4,
    localparam int CHK_W = secded_pkg::chk_count(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enc_vld_i,
    input logic             enc_vld_o,
    input logic [CW_W-1:0]  enc_word_o,
    input logic             dec_vld_i,
    input logic             dec_vld_o,
    input logic [CHK_W-1:0] dec_syn_o,
    input logic             dec_fix_o,
    input logic             dec_bad_o
);
    // R4
    enc_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) enc_vld_i |=> enc_vld_o);
    // R4
    enc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !enc_vld_i |=> !enc_vld_o);
    // R4
    dec_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) dec_vld_i |=> dec_vld_o);
    // R4
    dec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !dec_vld_i |=> !dec_vld_o);
    // R3
    even_par_chk: assert property (@(posedge clk) disable iff (!rst_n) enc_vld_o |-> (^enc_word_o) == 1'b0);
    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) dec_vld_o |-> !(dec_fix_o && dec_bad_o));
    // R5
    clean_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld_o && !dec_fix_o && !dec_bad_o) |-> dec_syn_o == '0);
    // R9
    bad_syn_chk: assert property (@(posedge clk) disable iff (!rst_n) (dec_vld_o && dec_bad_o) |-> dec_syn_o != '0);
endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enc_vld_i  (enc_vld_i),
    .enc_vld_o  (enc_vld_o),
    .enc_word_o (enc_word_o),
    .dec_vld_i  (dec_vld_i),
    .dec_vld_o  (dec_vld_o),
    .dec_syn_o  (dec_syn_o),
    .dec_fix_o  (dec_fix_o),
    .dec_bad_o  (dec_bad_o)
);

// File: tb/sim_secded_codec.sv
module sim_secded_codec;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_vld_i = 1'b0;
    logic [3:0] enc_data_i = '0;
    logic       enc_vld_o;
    logic [7:0] enc_word_o;
    logic       dec_vld_i = 1'b0;
    logic [7:0] dec_word_i = '0;
    logic       dec_vld_o;
    logic [3:0] dec_data_o;
    logic [2:0] dec_syn_o;
    logic       dec_fix_o;
    logic       dec_bad_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] word;
        int         due;
    } enc_exp_t;

    typedef struct {
        logic [3:0] data;
        logic [2:0] syn;
        logic       fix;
        logic       bad;
        bit         data_chk;
        string      tag;
        int         due;
    } dec_exp_t;

    enc_exp_t enc_q[$];
    dec_exp_t dec_q[$];

    secded_codec u0 (
        .clk(clk), .rst_n(rst_n),
        .enc_vld_i(enc_vld_i), .enc_data_i(enc_data_i),
        .enc_vld_o(enc_vld_o), .enc_word_o(enc_word_o),
        .dec_vld_i(dec_vld_i), .dec_word_i(dec_word_i),
        .dec_vld_o(dec_vld_o), .dec_data_o(dec_data_o),
        .dec_syn_o(dec_syn_o), .dec_fix_o(dec_fix_o), .dec_bad_o(dec_bad_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // reference encoder written from the layout in R1..R3
    function automatic logic [7:0] ref_enc(input logic [3:0] d);
        logic c1, c2, c3;
        logic [6:0] w;
        c1 = d[0] ^ d[1] ^ d[3];
        c2 = d[0] ^ d[2] ^ d[3];
        c3 = d[1] ^ d[2] ^ d[3];
        w  = {d[3], d[2], d[1], c3, d[0], c2, c1};
        return {^w, w};
    endfunction

    task automatic drive_enc(input logic [3:0] d);
        enc_exp_t e;
        @(negedge clk);
        enc_vld_i  = 1'b1;
        enc_data_i = d;
        e.word = ref_enc(d);
        e.due  = cyc + 1;
        enc_q.push_back(e);
        @(negedge clk);
        enc_vld_i = 1'b0;
    endtask

    // posA/posB: code positions 1..8 (8 = parity bit), 0 = no flip
    task automatic drive_dec(input logic [3:0] d, input int posA, input int posB, input bit hold);
        dec_exp_t e;
        logic [7:0] w;
        int nflip;
        int sa, sb;
        w = ref_enc(d);
        nflip = 0;
        if (posA != 0) begin w[posA-1] = ~w[posA-1]; nflip++; end
        if (posB != 0) begin w[posB-1] = ~w[posB-1]; nflip++; end
        sa = (posA == 8) ? 0 : posA;
        sb = (posB == 8) ? 0 : posB;
        e.data = d;
        e.syn  = 3'(sa ^ sb);
        e.fix  = (nflip == 1);
        e.bad  = (nflip == 2);
        e.data_chk = (nflip < 2);
        if (nflip == 0)      e.tag = "R5";
        else if (nflip == 2) e.tag = "R9";
        else if (sa == 0)    e.tag = "R8";
        else if (sa == 1 || sa == 2 || sa == 4) e.tag = "R7";
        else                 e.tag = "R6";
        @(negedge clk);
        dec_vld_i  = 1'b1;
        dec_word_i = w;
        e.due = cyc + 1;
        dec_q.push_back(e);
        if (!hold) begin
            @(negedge clk);
            dec_vld_i = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (enc_vld_o) begin
                if (enc_q.size() == 0) check(1'b0, "R4 enc extra valid", 1, 0);
                else begin
                    enc_exp_t e;
                    e = enc_q.pop_front();
                    check(cyc == e.due, "R4 enc latency", cyc, e.due);
                    check({enc_word_o[6:4], enc_word_o[2]} == {e.word[6:4], e.word[2]}, "R1 data positions",
                          enc_word_o, e.word);
                    check({enc_word_o[3], enc_word_o[1:0]} == {e.word[3], e.word[1:0]}, "R2 check bits",
                          enc_word_o, e.word);
                    check(enc_word_o[7] == e.word[7] && (^enc_word_o) == 1'b0, "R3 parity", enc_word_o, e.word);
                end
            end else if (enc_q.size() != 0 && enc_q[0].due <= cyc) begin
                check(1'b0, "R4 enc missing valid", 0, 1);
                void'(enc_q.pop_front());
            end
            if (dec_vld_o) begin
                if (dec_q.size() == 0) check(1'b0, "R4 dec extra valid", 1, 0);
                else begin
                    dec_exp_t e;
                    e = dec_q.pop_front();
                    check(cyc == e.due, "R4 dec latency", cyc, e.due);
                    if (e.data_chk) check(dec_data_o == e.data, {e.tag, " data"}, dec_data_o, e.data);
                    check(dec_syn_o == e.syn, {e.tag, " syndrome"}, dec_syn_o, e.syn);
                    check(dec_fix_o == e.fix, {e.tag, " corrected flag"}, dec_fix_o, e.fix);
                    check(dec_bad_o == e.bad, {e.tag, " uncorrectable flag"}, dec_bad_o, e.bad);
                    check(!(dec_fix_o && dec_bad_o), "R11 flags exclusive", {dec_fix_o, dec_bad_o}, 0);
                end
            end else if (dec_q.size() != 0 && dec_q[0].due <= cyc) begin
                check(1'b0, "R4 dec missing valid", 0, 1);
                void'(dec_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check({enc_vld_o, dec_vld_o} == 2'b00, "R10 valids in reset", {enc_vld_o, dec_vld_o}, 0);
        check(enc_word_o == 8'h00 && dec_data_o == 4'h0, "R10 results in reset", {enc_word_o, dec_data_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({enc_vld_o, dec_vld_o, dec_syn_o, dec_fix_o, dec_bad_o} == '0, "R10 idle after reset",
              {enc_vld_o, dec_vld_o, dec_syn_o, dec_fix_o, dec_bad_o}, 0);

        // encoder: all data values, with gaps
        for (int d = 0; d < 16; d++) drive_enc(4'(d));

        // R5: clean decode, back-to-back
        for (int d = 0; d < 16; d++) drive_dec(4'(d), 0, 0, 1'b1);
        @(negedge clk); dec_vld_i = 1'b0;

        // R6 R7 R8: every single flip, for several data values
        for (int k = 0; k < 4; k++) begin
            for (int p = 1; p <= 8; p++) drive_dec(4'(k * 5 + 1), p, 0, (p % 2) == 0);
        end
        @(negedge clk); dec_vld_i = 1'b0;

        // R9: every pair of flips
        for (int k = 0; k < 4; k++) begin
            for (int a = 1; a <= 8; a++) begin
                for (int b = a + 1; b <= 8; b++) drive_dec(4'(k * 4 + 3), a, b, 1'b1);
            end
        end
        @(negedge clk); dec_vld_i = 1'b0;

        // simultaneous encode and decode traffic, R4 on both paths
        fork
            for (int d = 0; d < 8; d++) drive_enc(4'(15 - d));
            for (int d = 0; d < 8; d++) drive_dec(4'(d), 6, 0, 1'b0);
        join

        repeat (4) @(negedge clk);
        check(enc_q.size() == 0 && dec_q.size() == 0, "R4 all results seen", enc_q.size() + dec_q.size(), 0);
        check(!enc_vld_o && !dec_vld_o, "R4 valids drop when idle", {enc_vld_o, dec_vld_o}, 0);
        finish_run();
    end

endmodule